// File: doc/BRIEF.md
# Plug-and-Play Logical Device Configuration Registers

This block keeps the configuration state of one logical device on an ISA Plug-and-Play card. Software sets it up through an index/data register port. Writing an index selects a register, and a write strobe or a read strobe then moves one byte. The block holds five kinds of state:

- an activation bit;
- a two-bit I/O range-check control;
- two memory descriptors, each with a base, a width control and a range-length mask;
- a 16-bit I/O base;
- the decode-enable outputs that the rest of the card uses, which are derived from the state above.

The block also contains the range-check responder. While the device is inactive and range check is on, a host I/O read that falls inside the programmed 16-byte window is answered with a fixed test byte. Configuration software reads that byte back to find address conflicts before it activates the device.

Top module: `pnp_ldev_cfg`

## Requirements
- R1: A synchronous active-high reset clears every register to zero. After reset the device is inactive, range check is disabled, and every implemented index reads 0x00.
- R2: Index 0x30 holds the activation bit in bit 0, and `dev_active` follows it one cycle after the write. Bits 7:1 are discarded on write and read as zero.
- R3: Index 0x31 holds the range-check enable in bit 1 and the pattern select in bit 0. Bits 7:2 are discarded on write and read as zero.
- R4: Range check responds when four conditions hold together: the device is inactive, range check is enabled, `io_rd` is high, and `io_addr[15:4]` equals the I/O base bits 15:4. In that case `chk_drive` is 1 and `chk_data` is 0x55 when the pattern select is 1, or 0xAA when it is 0. In every other case `chk_drive` is 0 and `chk_data` is 0x00.
- R5: While the device is active, range check has no effect: `chk_drive` stays 0 whatever the range-check register holds.
- R6: Each memory descriptor d (d = 0, 1) starts at index 0x40 + 8·d. Offset 0 holds base bits 15:8 of the page number, offset 1 holds base bits 7:0, offset 3 holds mask bits 15:8 and offset 4 holds mask bits 7:0. All four are read/write.
- R7: Offset 2 of each descriptor is its control register. Bit 1 is read/write and drives `mem_wide[d]`, where 1 means 16-bit access. Bit 0 and bits 7:2 always read zero.
- R8: `mem_hit[d]` is 1 exactly when the device is active and (`mem_page` AND mask) equals the base, where `mem_page` is address bits 23:8.
- R9: Index 0x60 holds I/O base bits 15:8 and index 0x61 holds bits 7:0, both read/write. `io_hit` is 1 exactly when the device is active and `io_addr[15:4]` equals base bits 15:4.
- R10: Reads of unimplemented indices return 0x00, and writes to them change no register.
- R11: `reg_rdata` carries the selected register in the same cycle that `reg_rd` is high. It is 0x00 whenever `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, combinational |
| mem_page | input | 16 | Host memory address bits 23:8 |
| io_addr | input | 16 | Host I/O address |
| io_rd | input | 1 | Host I/O read strobe |
| dev_active | output | 1 | Logical device active |
| mem_hit | output | 2 | Per-descriptor memory decode hit |
| mem_wide | output | 2 | Per-descriptor 16-bit access select |
| io_hit | output | 1 | I/O window decode hit |
| chk_drive | output | 1 | Range-check responder drives the bus |
| chk_data | output | 8 | Range-check response byte |

## Verification
The bench writes all-ones to the reserved bits, the read-only bits and the unimplemented indices, then reads them back as zero. A design that stored those bits would return nonzero values or corrupt a neighbouring register. It checks both response patterns, addresses one step outside the I/O window, and range check while the device is active. A design that ignored activation would drive the test byte over the live decode. It places memory addresses just inside and just outside each mask-defined window, which catches a mask applied to the wrong side of the comparison or descriptors whose indices are swapped.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;

    localparam logic [7:0] IDX_ACTIVATE  = 8'h30;
    localparam logic [7:0] IDX_RANGECHK  = 8'h31;
    localparam logic [7:0] IDX_MEM_FIRST = 8'h40;
    localparam logic [7:0] IDX_IO_HI     = 8'h60;
    localparam logic [7:0] IDX_IO_LO     = 8'h61;
    localparam int         DESC_STRIDE   = 8;
    localparam int         DESC_FIELDS   = 5;
    localparam int         PAGE_W        = 16;

    typedef enum logic [2:0] {
        MF_BASE_HI = 3'd0,
        MF_BASE_LO = 3'd1,
        MF_CTRL    = 3'd2,
        MF_MASK_HI = 3'd3,
        MF_MASK_LO = 3'd4
    } mem_field_e;

    typedef struct packed {
        logic [PAGE_W-1:0] base;
        logic              wide;
        logic [PAGE_W-1:0] mask;
    } mem_desc_t;

    typedef struct packed {
        logic        active;
        logic        chk_en;
        logic        chk_pat;
        logic [15:0] io_base;
    } dev_ctl_t;

    function automatic logic [7:0] chk_pattern(input logic pat);
        return pat ? 8'h55 : 8'hAA;
    endfunction

    function automatic logic [7:0] desc_first(input int d);
        return 8'(int'(IDX_MEM_FIRST) + DESC_STRIDE * d);
    endfunction

endpackage

// File: rtl/pnp_reg_file.sv
module pnp_reg_file
    import pnp_cfg_pkg::*;
#(
    parameter int MEM_DESCS = 2,
    parameter int WIN_BITS  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           reg_idx,
    input  logic [7:0]           reg_wdata,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    output logic [7:0]           reg_rdata,
    output mem_desc_t            desc_o [MEM_DESCS],
    output logic                 active_o,
    output logic                 chk_en_o,
    output logic                 chk_pat_o,
    output logic [15-WIN_BITS:0] io_page_o
);

    dev_ctl_t  ctl_q;
    mem_desc_t desc_q [MEM_DESCS];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            for (int d = 0; d < MEM_DESCS; d++) desc_q[d] <= '0;
        end else if (reg_wr) begin
            case (reg_idx)
                IDX_ACTIVATE: ctl_q.active <= reg_wdata[0];
                IDX_RANGECHK: begin
                    ctl_q.chk_en  <= reg_wdata[1];
                    ctl_q.chk_pat <= reg_wdata[0];
                end
                IDX_IO_HI: ctl_q.io_base[15:8] <= reg_wdata;
                IDX_IO_LO: ctl_q.io_base[7:0]  <= reg_wdata;
                default: ;
            endcase
            for (int d = 0; d < MEM_DESCS; d++) begin
                if (reg_idx - desc_first(d) < 8'(DESC_FIELDS)) begin
                    case (mem_field_e'(3'(reg_idx - desc_first(d))))
                        MF_BASE_HI: desc_q[d].base[15:8] <= reg_wdata;
                        MF_BASE_LO: desc_q[d].base[7:0]  <= reg_wdata;
                        MF_CTRL:    desc_q[d].wide       <= reg_wdata[1];
                        MF_MASK_HI: desc_q[d].mask[15:8] <= reg_wdata;
                        MF_MASK_LO: desc_q[d].mask[7:0]  <= reg_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_rd) begin
            case (reg_idx)
                IDX_ACTIVATE: reg_rdata = {7'b0, ctl_q.active};
                IDX_RANGECHK: reg_rdata = {6'b0, ctl_q.chk_en, ctl_q.chk_pat};
                IDX_IO_HI:    reg_rdata = ctl_q.io_base[15:8];
                IDX_IO_LO:    reg_rdata = ctl_q.io_base[7:0];
                default: ;
            endcase
            for (int d = 0; d < MEM_DESCS; d++) begin
                if (reg_idx - desc_first(d) < 8'(DESC_FIELDS)) begin
                    case (mem_field_e'(3'(reg_idx - desc_first(d))))
                        MF_BASE_HI: reg_rdata = desc_q[d].base[15:8];
                        MF_BASE_LO: reg_rdata = desc_q[d].base[7:0];
                        MF_CTRL:    reg_rdata = {6'b0, desc_q[d].wide, 1'b0};
                        MF_MASK_HI: reg_rdata = desc_q[d].mask[15:8];
                        MF_MASK_LO: reg_rdata = desc_q[d].mask[7:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    assign desc_o    = desc_q;
    assign active_o  = ctl_q.active;
    assign chk_en_o  = ctl_q.chk_en;
    assign chk_pat_o = ctl_q.chk_pat;
    assign io_page_o = ctl_q.io_base[15:WIN_BITS];

endmodule

// File: rtl/pnp_mem_decode.sv
module pnp_mem_decode
    import pnp_cfg_pkg::*;
(
    input  logic              active,
    input  logic [PAGE_W-1:0] page,
    input  mem_desc_t         desc,
    output logic              hit,
    output logic              wide
);

    logic [PAGE_W-1:0] masked;

    assign masked = page & desc.mask;
    assign hit    = active && (masked == desc.base);
    assign wide   = desc.wide;

endmodule

// File: rtl/pnp_io_decode.sv
module pnp_io_decode
    import pnp_cfg_pkg::*;
#(
    parameter int WIN_BITS = 4
) (
    input  logic                 active,
    input  logic                 chk_en,
    input  logic                 chk_pat,
    input  logic [15-WIN_BITS:0] io_page,
    input  logic [15:0]          io_addr,
    input  logic                 io_rd,
    output logic                 io_hit,
    output logic                 chk_drive,
    output logic [7:0]           chk_data
);

    logic in_window;

    assign in_window = (io_addr[15:WIN_BITS] == io_page);
    assign io_hit    = active && in_window;
    assign chk_drive = !active && chk_en && io_rd && in_window;
    assign chk_data  = chk_drive ? chk_pattern(chk_pat) : 8'h00;

endmodule

// File: rtl/pnp_ldev_cfg.sv
module pnp_ldev_cfg
    import pnp_cfg_pkg::*;
#(
    parameter int MEM_DESCS = 2,
    parameter int WIN_BITS  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           reg_idx,
    input  logic [7:0]           reg_wdata,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    output logic [7:0]           reg_rdata,
    input  logic [PAGE_W-1:0]    mem_page,
    input  logic [15:0]          io_addr,
    input  logic                 io_rd,
    output logic                 dev_active,
    output logic [MEM_DESCS-1:0] mem_hit,
    output logic [MEM_DESCS-1:0] mem_wide,
    output logic                 io_hit,
    output logic                 chk_drive,
    output logic [7:0]           chk_data
);

    mem_desc_t            desc [MEM_DESCS];
    logic                 chk_en;
    logic                 chk_pat;
    logic [15-WIN_BITS:0] io_page;

    pnp_reg_file #(.MEM_DESCS(MEM_DESCS), .WIN_BITS(WIN_BITS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .desc_o    (desc),
        .active_o  (dev_active),
        .chk_en_o  (chk_en),
        .chk_pat_o (chk_pat),
        .io_page_o (io_page)
    );

    for (genvar d = 0; d < MEM_DESCS; d++) begin : g_mem
        pnp_mem_decode u_dec (
            .active (dev_active),
            .page   (mem_page),
            .desc   (desc[d]),
            .hit    (mem_hit[d]),
            .wide   (mem_wide[d])
        );
    end

    pnp_io_decode #(.WIN_BITS(WIN_BITS)) u_io (
        .active    (dev_active),
        .chk_en    (chk_en),
        .chk_pat   (chk_pat),
        .io_page   (io_page),
        .io_addr   (io_addr),
        .io_rd     (io_rd),
        .io_hit    (io_hit),
        .chk_drive (chk_drive),
        .chk_data  (chk_data)
    );

endmodule

// File: rtl/pnp_ldev_cfg_checker.sv
module pnp_ldev_cfg_checker #(
    parameter int MEM_DESCS = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [7:0]           reg_idx,
    input logic                 wd0,
    input logic                 reg_wr,
    input logic                 reg_rd,
    input logic [7:0]           reg_rdata,
    input logic                 io_rd,
    input logic                 dev_active,
    input logic [MEM_DESCS-1:0] mem_hit,
    input logic                 io_hit,
    input logic                 chk_drive,
    input logic [7:0]           chk_data
);

    assert_activate_write_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_idx == 8'h30) |=> (dev_active == $past(wd0)));

    assert_activate_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_idx == 8'h30) |=> $stable(dev_active));

    assert_chk_pattern_R4: assert property (@(posedge clk) disable iff (rst)
        chk_drive |-> (io_rd && (chk_data == 8'h55 || chk_data == 8'hAA)));

    assert_chk_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !chk_drive |-> (chk_data == 8'h00));

    assert_chk_off_when_active_R5: assert property (@(posedge clk) disable iff (rst)
        dev_active |-> !chk_drive);

    assert_mem_needs_active_R8: assert property (@(posedge clk) disable iff (rst)
        !dev_active |-> (mem_hit == '0));

    assert_io_needs_active_R9: assert property (@(posedge clk) disable iff (rst)
        !dev_active |-> !io_hit);

    assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |-> (reg_rdata == 8'h00));

endmodule

bind pnp_ldev_cfg pnp_ldev_cfg_checker #(.MEM_DESCS(MEM_DESCS)) i_checker (
    .clk        (clk),
    .rst        (rst),
    .reg_idx    (reg_idx),
    .wd0        (reg_wdata[0]),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .io_rd      (io_rd),
    .dev_active (dev_active),
    .mem_hit    (mem_hit),
    .io_hit     (io_hit),
    .chk_drive  (chk_drive),
    .chk_data   (chk_data)
);

// File: tb/test_pnp_ldev_cfg.sv
`timescale 1ns/1ps
module test_pnp_ldev_cfg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic [15:0] mem_page = '0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        dev_active;
    logic [1:0]  mem_hit;
    logic [1:0]  mem_wide;
    logic        io_hit;
    logic        chk_drive;
    logic [7:0]  chk_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pnp_ldev_cfg i_pnp_ldev_cfg (
        .clk(clk), .rst(rst), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .mem_page(mem_page), .io_addr(io_addr), .io_rd(io_rd),
        .dev_active(dev_active), .mem_hit(mem_hit), .mem_wide(mem_wide),
        .io_hit(io_hit), .chk_drive(chk_drive), .chk_data(chk_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        reg_idx = idx; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] idx, output logic [7:0] v);
        @(negedge clk);
        reg_idx = idx; reg_rd = 1'b1;
        #1 v = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic expect_rd(input string req, input logic [7:0] idx, input logic [7:0] exp);
        logic [7:0] v;
        rd(idx, v);
        chk(req, int'(v), int'(exp));
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [7:0] idxs [13] = '{8'h30, 8'h31, 8'h40, 8'h41, 8'h42, 8'h43, 8'h44,
                                  8'h48, 8'h49, 8'h4A, 8'h4B, 8'h4C, 8'h60};
        for (int i = 0; i < 13; i++) expect_rd("R1 reg after reset", idxs[i], 8'h00);
        expect_rd("R1 io lo after reset", 8'h61, 8'h00);
        chk("R1 inactive after reset", int'(dev_active), 0);
    endtask

    task automatic t_activate_reg();
        wr(8'h30, 8'hFE);
        expect_rd("R2 reserved bits read zero", 8'h30, 8'h00);
        chk("R2 stays inactive", int'(dev_active), 0);
        wr(8'h30, 8'hFF);
        expect_rd("R2 activate readback", 8'h30, 8'h01);
        chk("R2 active flag", int'(dev_active), 1);
        wr(8'h30, 8'h00);
        chk("R2 deactivate", int'(dev_active), 0);
    endtask

    task automatic t_rangechk_reg();
        wr(8'h31, 8'hFF);
        expect_rd("R3 range-check readback", 8'h31, 8'h03);
        wr(8'h31, 8'hFD);
        expect_rd("R3 pattern clear", 8'h31, 8'h01);
        wr(8'h31, 8'h00);
        expect_rd("R3 cleared", 8'h31, 8'h00);
    endtask

    task automatic t_mem_regs();
        wr(8'h40, 8'h12); wr(8'h41, 8'h34); wr(8'h43, 8'h56); wr(8'h44, 8'h78);
        wr(8'h48, 8'h9A); wr(8'h49, 8'hBC); wr(8'h4B, 8'hDE); wr(8'h4C, 8'hF1);
        expect_rd("R6 d0 base hi", 8'h40, 8'h12);
        expect_rd("R6 d0 base lo", 8'h41, 8'h34);
        expect_rd("R6 d0 mask hi", 8'h43, 8'h56);
        expect_rd("R6 d0 mask lo", 8'h44, 8'h78);
        expect_rd("R6 d1 base hi", 8'h48, 8'h9A);
        expect_rd("R6 d1 base lo", 8'h49, 8'hBC);
        expect_rd("R6 d1 mask hi", 8'h4B, 8'hDE);
        expect_rd("R6 d1 mask lo", 8'h4C, 8'hF1);
        wr(8'h42, 8'hFF);
        wr(8'h4A, 8'h01);
        expect_rd("R7 d0 ctrl readback", 8'h42, 8'h02);
        expect_rd("R7 d1 ctrl readback", 8'h4A, 8'h00);
        chk("R7 wide select", int'(mem_wide), 1);
    endtask

    task automatic t_unimplemented();
        wr(8'h45, 8'hFF); wr(8'h4D, 8'hFF); wr(8'h50, 8'hFF);
        wr(8'h62, 8'hFF); wr(8'h00, 8'hFF); wr(8'h38, 8'hFF);
        expect_rd("R10 idx 45 reads zero", 8'h45, 8'h00);
        expect_rd("R10 idx 4D reads zero", 8'h4D, 8'h00);
        expect_rd("R10 idx 50 reads zero", 8'h50, 8'h00);
        expect_rd("R10 idx 62 reads zero", 8'h62, 8'h00);
        expect_rd("R10 d0 mask lo untouched", 8'h44, 8'h78);
        expect_rd("R10 d1 base hi untouched", 8'h48, 8'h9A);
        expect_rd("R10 io lo untouched", 8'h61, 8'h00);
        expect_rd("R10 activate untouched", 8'h30, 8'h00);
    endtask

    task automatic t_io_decode();
        wr(8'h60, 8'h03); wr(8'h61, 8'h47);
        expect_rd("R9 io hi", 8'h60, 8'h03);
        expect_rd("R9 io lo", 8'h61, 8'h47);
        @(negedge clk); io_addr = 16'h0340; #1;
        chk("R9 inactive no io hit", int'(io_hit), 0);
        wr(8'h30, 8'h01);
        io_addr = 16'h0340; #1;
        chk("R9 io hit low edge", int'(io_hit), 1);
        io_addr = 16'h034F; #1;
        chk("R9 io hit high edge", int'(io_hit), 1);
        io_addr = 16'h0350; #1;
        chk("R9 io miss above", int'(io_hit), 0);
        io_addr = 16'h033F; #1;
        chk("R9 io miss below", int'(io_hit), 0);
        wr(8'h30, 8'h00);
    endtask

    task automatic t_range_check();
        wr(8'h31, 8'h03);
        @(negedge clk); io_addr = 16'h0345; io_rd = 1'b1; #1;
        chk("R4 drive 55", int'(chk_drive), 1);
        chk("R4 pattern 55", int'(chk_data), 'h55);
        wr(8'h31, 8'h02);
        #1;
        chk("R4 pattern AA", int'(chk_data), 'hAA);
        io_addr = 16'h0350; #1;
        chk("R4 outside window quiet", int'(chk_drive), 0);
        chk("R4 outside window data", int'(chk_data), 0);
        io_addr = 16'h0341; io_rd = 1'b0; #1;
        chk("R4 no read quiet", int'(chk_drive), 0);
        io_rd = 1'b1;
        wr(8'h30, 8'h01);
        #1;
        chk("R5 active suppresses check", int'(chk_drive), 0);
        chk("R5 active data zero", int'(chk_data), 0);
        chk("R5 normal decode hit", int'(io_hit), 1);
        wr(8'h30, 8'h00);
        wr(8'h31, 8'h01);
        #1;
        chk("R4 disabled quiet", int'(chk_drive), 0);
        io_rd = 1'b0;
    endtask

    task automatic t_mem_decode();
        wr(8'h40, 8'h0C); wr(8'h41, 8'h00); wr(8'h43, 8'hFF); wr(8'h44, 8'h00);
        wr(8'h48, 8'h00); wr(8'h49, 8'hD0); wr(8'h4B, 8'hFF); wr(8'h4C, 8'hF0);
        @(negedge clk); mem_page = 16'h0C12; #1;
        chk("R8 inactive no mem hit", int'(mem_hit), 0);
        wr(8'h30, 8'h01);
        mem_page = 16'h0C12; #1;
        chk("R8 d0 hit", int'(mem_hit), 1);
        mem_page = 16'h0CFF; #1;
        chk("R8 d0 hit top", int'(mem_hit), 1);
        mem_page = 16'h0D00; #1;
        chk("R8 d0 miss", int'(mem_hit), 0);
        mem_page = 16'h00D5; #1;
        chk("R8 d1 hit", int'(mem_hit), 2);
        mem_page = 16'h00E0; #1;
        chk("R8 d1 miss", int'(mem_hit), 0);
        wr(8'h30, 8'h00);
    endtask

    task automatic t_read_strobe();
        @(negedge clk); reg_idx = 8'h40; reg_rd = 1'b0; #1;
        chk("R11 no strobe zero", int'(reg_rdata), 0);
        reg_rd = 1'b1; #1;
        chk("R11 same-cycle data", int'(reg_rdata), 'h0C);
        reg_rd = 1'b0;
    endtask

    task automatic t_midrun_reset();
        wr(8'h30, 8'h01);
        do_reset();
        chk("R1 reset deactivates", int'(dev_active), 0);
        expect_rd("R1 reset clears d0 base", 8'h40, 8'h00);
        expect_rd("R1 reset clears d1 mask", 8'h4C, 8'h00);
        expect_rd("R1 reset clears io base", 8'h60, 8'h00);
        expect_rd("R1 reset clears range check", 8'h31, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_activate_reg();
        t_rangechk_reg();
        t_mem_regs();
        t_unimplemented();
        t_io_decode();
        t_range_check();
        t_mem_decode();
        t_read_strobe();
        t_midrun_reset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule